// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a 32-bit single-cycle processor core that executes one instruction per clock. It is purely combinational. It reads the primary operation field (instruction bits 31:26), the function field (bits 5:0) and the zero flag from the core's ALU. From these it drives every select and enable that the surrounding datapath needs: the next-PC source, the write-address source, the write-data source, the two ALU operand sources, the immediate extension mode, the 5-bit ALU function code, and the write enables for the register file and the data memory.

An operation field of zero means a register-format instruction, and the function field then picks the operation. Every other operation field stands on its own. Conditional branches are resolved inside the decoder. The ALU subtracts the two registers, and the decoder turns the zero flag into the next-PC choice. The upper-immediate load is run as a left shift of the immediate by a constant 16, which enters on the A operand. Any encoding the decoder does not recognise suppresses all state changes and raises an illegal-instruction flag.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: With opcode 000000, the register ALU functions give rd writes of the ALU result (wa_sel 0, wd_sel 1, a_sel 0, b_sel 0, rf_we 1). The codes are: add 100000 and addu 100001 give alu_fn 00001; sub 100010 and subu 100011 give 10001; and 100100 gives 00000; or 100101 gives 00100; xor 100110 gives 01000; nor 100111 gives 01100.
- R2: Register shifts have funct 000000 (sll), 000010 (srl) and 000011 (sra), which set a_sel 1 (shamt). Their variable forms are funct 000100, 000110 and 000111, which set a_sel 0 (rs). All of them take b_sel 0 and write rd. alu_fn is 00010 for left, 01010 for logical right and 01110 for arithmetic right.
- R3: Compares write a 0 or 1 result. slt is funct 101010 with alu_fn 10101, and sltu is funct 101011 with alu_fn 11101; both write rd. slti is opcode 001010 and sltiu is opcode 001011, with the same codes; both write rt (wa_sel 1), take b_sel 1 and use imm_sext 1.
- R4: The immediate ALU opcodes write rt with the ALU result and use b_sel 1. addi 001000 and addiu 001001 give alu_fn 00001 with imm_sext 1. andi 001100, ori 001101 and xori 001110 give alu_fn 00000, 00100 and 01000 with imm_sext 0.
- R5: lui (opcode 001111) sets a_sel 2 (the constant 16), b_sel 1, imm_sext 0 and alu_fn 00010, and writes rt with the ALU result.
- R6: lw (opcode 100011) sets alu_fn 00001, b_sel 1 and imm_sext 1, and writes rt from memory data (wd_sel 2). sw (opcode 101011) uses the same address settings but sets mem_we 1 and rf_we 0.
- R7: beq (000100) and bne (000101) set alu_fn 10001 and write nothing. pc_sel is 2 (branch target) when alu_zero is 1 for beq, or 0 for bne. Otherwise pc_sel is 0 (PC+4).
- R8: j (000010) sets pc_sel 3 (jump address) and writes nothing. jal (000011) sets pc_sel 3 and writes PC+4 (wd_sel 0) into register 31 (wa_sel 2).
- R9: jr (funct 001000) sets pc_sel 1 (register target) and writes nothing. jalr (funct 001001) sets pc_sel 1 and writes PC+4 (wd_sel 0) into rd (wa_sel 0).
- R10: Any opcode, or any funct under opcode 000000, not listed in R1 to R9 sets illegal_op 1, rf_we 0, mem_we 0 and pc_sel 0. illegal_op is 0 for every listed encoding.
- R11: A field an instruction does not use holds its rest value: pc_sel 0, wa_sel 0, wd_sel 1, a_sel 0, b_sel 0, imm_sext 1, alu_fn 00001. funct has no effect when opcode is nonzero. alu_zero has no effect outside beq and bne.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| funct | input | 6 | Instruction bits 5:0 |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_sel | output | 2 | Next PC: 0 PC+4, 1 register, 2 branch, 3 jump |
| wa_sel | output | 2 | Write address: 0 rd, 1 rt, 2 register 31 |
| wd_sel | output | 2 | Write data: 0 PC+4, 1 ALU, 2 memory |
| a_sel | output | 2 | ALU A: 0 register port 1, 1 shamt, 2 constant 16 |
| b_sel | output | 1 | ALU B: 0 register port 2, 1 extended immediate |
| imm_sext | output | 1 | 1 sign-extends, 0 zero-extends the immediate |
| alu_fn | output | 5 | ALU function code |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| illegal_op | output | 1 | Unrecognised instruction |

## Verification
Two things can meet in one decode: resolving a branch from the zero flag and recognising the encoding. A mistake in either one can make an unknown or non-branch instruction redirect the PC. The sweep applies every opcode with every funct under both zero-flag values, so every illegal encoding and every jump is seen with alu_zero high and low. Each output vector is compared in full against a model built from the requirement tables. This flags both a flag leak into pc_sel and a write enable left on for a rejected instruction.

// File: rtl/sc_ctrl_pkg.sv
// Shared encodings and the internal control bundle of the decoder.
// Assumes a 6-bit opcode and a 6-bit function field.
package sc_ctrl_pkg;
    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 5;
    localparam int SEL_W = 2;

    localparam logic [ALU_W-1:0] ALU_ADD  = 5'b00001;
    localparam logic [ALU_W-1:0] ALU_SUB  = 5'b10001;
    localparam logic [ALU_W-1:0] ALU_SLT  = 5'b10101;
    localparam logic [ALU_W-1:0] ALU_SLTU = 5'b11101;
    localparam logic [ALU_W-1:0] ALU_SLL  = 5'b00010;
    localparam logic [ALU_W-1:0] ALU_SRL  = 5'b01010;
    localparam logic [ALU_W-1:0] ALU_SRA  = 5'b01110;
    localparam logic [ALU_W-1:0] ALU_AND  = 5'b00000;
    localparam logic [ALU_W-1:0] ALU_OR   = 5'b00100;
    localparam logic [ALU_W-1:0] ALU_XOR  = 5'b01000;
    localparam logic [ALU_W-1:0] ALU_NOR  = 5'b01100;

    typedef enum logic [1:0] {FLOW_SEQ, FLOW_REG, FLOW_BR, FLOW_ABS} flow_e;

    typedef struct packed {
        logic               ok;
        flow_e              flow;
        logic               br_ne;
        logic [SEL_W-1:0]   wa_sel;
        logic [SEL_W-1:0]   wd_sel;
        logic [SEL_W-1:0]   a_sel;
        logic               b_sel;
        logic               sext;
        logic [ALU_W-1:0]   fn;
        logic               rf_we;
        logic               mem_we;
    } ctl_t;

    // Rest values for every field; decoders override what they use.
    function automatic ctl_t ctl_rest();
        ctl_t c;
        c.ok     = 1'b0;
        c.flow   = FLOW_SEQ;
        c.br_ne  = 1'b0;
        c.wa_sel = 2'd0;
        c.wd_sel = 2'd1;
        c.a_sel  = 2'd0;
        c.b_sel  = 1'b0;
        c.sext   = 1'b1;
        c.fn     = ALU_ADD;
        c.rf_we  = 1'b0;
        c.mem_we = 1'b0;
        return c;
    endfunction
endpackage

// File: rtl/sc_rtype_dec.sv
// Decodes the function field of register-format instructions.
// Assumes the caller only uses the result when the opcode is zero.
module sc_rtype_dec
    import sc_ctrl_pkg::*;
(
    input  logic [FN_W-1:0] funct,
    output ctl_t            ctl
);
    // Map each function code to its control bundle.
    always_comb begin
        ctl = ctl_rest();
        ctl.ok     = 1'b1;
        ctl.rf_we  = 1'b1;
        case (funct)
            6'b100000, 6'b100001: ctl.fn = ALU_ADD;
            6'b100010, 6'b100011: ctl.fn = ALU_SUB;
            6'b100100: ctl.fn = ALU_AND;
            6'b100101: ctl.fn = ALU_OR;
            6'b100110: ctl.fn = ALU_XOR;
            6'b100111: ctl.fn = ALU_NOR;
            6'b101010: ctl.fn = ALU_SLT;
            6'b101011: ctl.fn = ALU_SLTU;
            6'b000000: begin ctl.fn = ALU_SLL; ctl.a_sel = 2'd1; end
            6'b000010: begin ctl.fn = ALU_SRL; ctl.a_sel = 2'd1; end
            6'b000011: begin ctl.fn = ALU_SRA; ctl.a_sel = 2'd1; end
            6'b000100: ctl.fn = ALU_SLL;
            6'b000110: ctl.fn = ALU_SRL;
            6'b000111: ctl.fn = ALU_SRA;
            6'b001000: begin ctl.flow = FLOW_REG; ctl.rf_we = 1'b0; end
            6'b001001: begin ctl.flow = FLOW_REG; ctl.wd_sel = 2'd0; end
            default: begin ctl.ok = 1'b0; ctl.rf_we = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sc_itype_dec.sv
// Decodes the opcode of immediate, memory, branch and jump instructions.
// Assumes opcode zero is handled by the register-format decoder.
module sc_itype_dec
    import sc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);
    // Map each opcode to its control bundle.
    always_comb begin
        ctl = ctl_rest();
        ctl.ok = 1'b1;
        if (opcode[5:3] == 3'b001) begin
            ctl.rf_we  = 1'b1;
            ctl.wa_sel = 2'd1;
            ctl.b_sel  = 1'b1;
            case (opcode[2:0])
                3'b000, 3'b001: ctl.fn = ALU_ADD;
                3'b010: ctl.fn = ALU_SLT;
                3'b011: ctl.fn = ALU_SLTU;
                3'b100: begin ctl.fn = ALU_AND; ctl.sext = 1'b0; end
                3'b101: begin ctl.fn = ALU_OR;  ctl.sext = 1'b0; end
                3'b110: begin ctl.fn = ALU_XOR; ctl.sext = 1'b0; end
                default: begin
                    ctl.fn    = ALU_SLL;
                    ctl.sext  = 1'b0;
                    ctl.a_sel = 2'd2;
                end
            endcase
        end else begin
            case (opcode)
                6'b100011: begin
                    ctl.rf_we = 1'b1; ctl.wa_sel = 2'd1;
                    ctl.wd_sel = 2'd2; ctl.b_sel = 1'b1;
                end
                6'b101011: begin ctl.mem_we = 1'b1; ctl.b_sel = 1'b1; end
                6'b000100: begin ctl.flow = FLOW_BR; ctl.fn = ALU_SUB; end
                6'b000101: begin
                    ctl.flow = FLOW_BR; ctl.fn = ALU_SUB; ctl.br_ne = 1'b1;
                end
                6'b000010: ctl.flow = FLOW_ABS;
                6'b000011: begin
                    ctl.flow = FLOW_ABS; ctl.rf_we = 1'b1;
                    ctl.wa_sel = 2'd2; ctl.wd_sel = 2'd0;
                end
                default: ctl.ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sc_pc_resolve.sv
// Turns the flow class and the ALU zero flag into the next-PC select.
// Assumes the ALU subtracts the two registers for branches.
module sc_pc_resolve
    import sc_ctrl_pkg::*;
(
    input  flow_e            flow,
    input  logic             br_ne,
    input  logic             ok,
    input  logic             zero,
    output logic [SEL_W-1:0] pc_sel
);
    // Taken branch when the flag matches the branch polarity.
    always_comb begin
        pc_sel = 2'd0;
        if (ok) begin
            case (flow)
                FLOW_REG: pc_sel = 2'd1;
                FLOW_BR:  pc_sel = (zero ^ br_ne) ? 2'd2 : 2'd0;
                FLOW_ABS: pc_sel = 2'd3;
                default:  pc_sel = 2'd0;
            endcase
        end
    end
endmodule

// File: rtl/sc_ctrl_decoder.sv
// Top-level control decoder for a single-cycle core: selects between the
// register-format and opcode decoders and gates enables on legality.
// Assumes a purely combinational use inside one clock cycle.
module sc_ctrl_decoder
    import sc_ctrl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    output logic [1:0] pc_sel,
    output logic [1:0] wa_sel,
    output logic [1:0] wd_sel,
    output logic [1:0] a_sel,
    output logic       b_sel,
    output logic       imm_sext,
    output logic [4:0] alu_fn,
    output logic       rf_we,
    output logic       mem_we,
    output logic       illegal_op
);
    ctl_t r_ctl, i_ctl, sel_ctl, out_ctl;

    sc_rtype_dec u_rdec (.funct(funct),   .ctl(r_ctl));
    sc_itype_dec u_idec (.opcode(opcode), .ctl(i_ctl));

    // Choose the decoder by the register-format opcode.
    always_comb sel_ctl = (opcode == '0) ? r_ctl : i_ctl;

    // Rejected encodings fall back to rest values with no writes.
    always_comb begin
        out_ctl = sel_ctl.ok ? sel_ctl : ctl_rest();
    end

    sc_pc_resolve u_pc (
        .flow(out_ctl.flow), .br_ne(out_ctl.br_ne), .ok(sel_ctl.ok),
        .zero(alu_zero), .pc_sel(pc_sel)
    );

    // Drive the datapath controls.
    always_comb begin
        wa_sel     = out_ctl.wa_sel;
        wd_sel     = out_ctl.wd_sel;
        a_sel      = out_ctl.a_sel;
        b_sel      = out_ctl.b_sel;
        imm_sext   = out_ctl.sext;
        alu_fn     = out_ctl.fn;
        rf_we      = out_ctl.rf_we;
        mem_we     = out_ctl.mem_we;
        illegal_op = ~sel_ctl.ok;
    end
endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
// Cross-output consistency checks for the control decoder, bound to it.
module sc_ctrl_decoder_chk (
    input logic [5:0] opcode,
    input logic [1:0] pc_sel,
    input logic [1:0] wa_sel,
    input logic [1:0] wd_sel,
    input logic [1:0] a_sel,
    input logic       rf_we,
    input logic       mem_we,
    input logic       illegal_op
);
    // Evaluate the output relations whenever the decode settles.
    always_comb begin
        a_r6_store_no_regwrite: assert (!(mem_we && rf_we));
        a_r10_illegal_quiet: assert (!illegal_op || (!rf_we && !mem_we && pc_sel == 2'd0));
        a_r7_branch_only: assert (pc_sel != 2'd2 || opcode[5:1] == 5'b00010);
        a_r8_link_r31: assert (wa_sel != 2'd2 || (opcode == 6'b000011 && wd_sel == 2'd0 && rf_we));
        a_r5_const16_lui: assert (a_sel != 2'd2 || opcode == 6'b001111);
        a_r9_reg_jump_rtype: assert (pc_sel != 2'd1 || opcode == 6'b000000);
    end
endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk u_chk (
    .opcode(opcode), .pc_sel(pc_sel), .wa_sel(wa_sel), .wd_sel(wd_sel),
    .a_sel(a_sel), .rf_we(rf_we), .mem_we(mem_we), .illegal_op(illegal_op)
);

// File: tb/test_sc_ctrl_decoder.sv
// Exhaustive sweep of opcode x funct x zero against a requirement model.
module test_sc_ctrl_decoder;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [5:0] opcode = '0, funct = '0;
    logic       alu_zero = 1'b0;
    logic [1:0] pc_sel, wa_sel, wd_sel, a_sel;
    logic       b_sel, imm_sext, rf_we, mem_we, illegal_op;
    logic [4:0] alu_fn;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    sc_ctrl_decoder i_sc_ctrl_decoder (
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
        .pc_sel(pc_sel), .wa_sel(wa_sel), .wd_sel(wd_sel), .a_sel(a_sel),
        .b_sel(b_sel), .imm_sext(imm_sext), .alu_fn(alu_fn),
        .rf_we(rf_we), .mem_we(mem_we), .illegal_op(illegal_op)
    );

    // Packed view: {ill, rf_we, mem_we, pc, wa, wd, a, b, sext, fn}
    function automatic logic [17:0] model(input logic [5:0] op,
                                          input logic [5:0] fn,
                                          input logic z);
        logic ill = 1'b0, we = 1'b0, mw = 1'b0, b = 1'b0, sx = 1'b1;
        logic [1:0] pc = 0, wa = 0, wd = 1, a = 0;
        logic [4:0] f = 5'd1;
        if (op == 6'd0) begin
            we = 1'b1;
            case (fn)
                32, 33: f = 5'd1;
                34, 35: f = 5'd17;
                36: f = 5'd0;
                37: f = 5'd4;
                38: f = 5'd8;
                39: f = 5'd12;
                42: f = 5'd21;
                43: f = 5'd29;
                0: begin f = 5'd2;  a = 1; end
                2: begin f = 5'd10; a = 1; end
                3: begin f = 5'd14; a = 1; end
                4: f = 5'd2;
                6: f = 5'd10;
                7: f = 5'd14;
                8: begin pc = 1; we = 0; end
                9: begin pc = 1; wd = 0; end
                default: begin ill = 1; we = 0; end
            endcase
        end else begin
            case (op)
                8, 9:  begin we = 1; wa = 1; b = 1; end
                10: begin we = 1; wa = 1; b = 1; f = 5'd21; end
                11: begin we = 1; wa = 1; b = 1; f = 5'd29; end
                12: begin we = 1; wa = 1; b = 1; sx = 0; f = 5'd0; end
                13: begin we = 1; wa = 1; b = 1; sx = 0; f = 5'd4; end
                14: begin we = 1; wa = 1; b = 1; sx = 0; f = 5'd8; end
                15: begin we = 1; wa = 1; b = 1; sx = 0; f = 5'd2; a = 2; end
                35: begin we = 1; wa = 1; wd = 2; b = 1; end
                43: begin mw = 1; b = 1; end
                4:  begin f = 5'd17; pc = z ? 2 : 0; end
                5:  begin f = 5'd17; pc = z ? 0 : 2; end
                2:  pc = 3;
                3:  begin pc = 3; we = 1; wa = 2; wd = 0; end
                default: ill = 1;
            endcase
        end
        return {ill, we, mw, pc, wa, wd, a, b, sx, f};
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 0) begin
            if (fn inside {0, 2, 3, 4, 6, 7}) return "R2";
            if (fn inside {42, 43}) return "R3";
            if (fn inside {8, 9}) return "R9";
            if (fn >= 32 && fn <= 39) return "R1";
            return "R10";
        end
        if (op inside {10, 11}) return "R3";
        if (op == 15) return "R5";
        if (op >= 8 && op <= 14) return "R4";
        if (op inside {35, 43}) return "R6";
        if (op inside {4, 5}) return "R7";
        if (op inside {2, 3}) return "R8";
        return "R10";
    endfunction

    task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                         input logic z, input string tag);
        logic [17:0] got, exp;
        @(negedge clk);
        opcode = op; funct = fn; alu_zero = z;
        #5;
        got = {illegal_op, rf_we, mem_we, pc_sel, wa_sel, wd_sel, a_sel,
               b_sel, imm_sext, alu_fn};
        exp = model(op, fn, z);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%h expected=%h",
                     tag, op, fn, z, got, exp);
        end
    endtask

    initial begin
        // Rest state at time zero: all-zero word decodes as sll (R2, R11).
        apply(6'd0, 6'd0, 1'b0, "R2");
        // Branch polarity corners (R7) and jal link (R8), funct junk (R11).
        apply(6'd4, 6'h3f, 1'b1, "R7");
        apply(6'd5, 6'h3f, 1'b1, "R7");
        apply(6'd3, 6'd8, 1'b1, "R8");
        // Full sweep: every opcode, funct and zero flag (R1-R11 by class).
        for (int op = 0; op < 64; op++)
            for (int fn = 0; fn < 64; fn++)
                for (int z = 0; z < 2; z++)
                    apply(op[5:0], fn[5:0], z[0],
                          (z == 1 && !(op inside {4, 5})) ? "R11" : req_of(op[5:0], fn[5:0]));
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule